// File: doc/BRIEF.md
# Interrupt Controller Configuration Write Decoder

This block sits behind the register port of an eight-input interrupt controller. It takes CPU writes through a one-bit address, an 8-bit data bus and a write enable. The meaning of each write depends on three things: the address bit, data bits 4 and 3, and how far the controller has got through its start-up word sequence. The sequence has variable length. A start word opens it. It is followed by a vector word, then an optional cascade word and an optional mode word, and the start word itself says which of the optional words will follow.

Once the sequence completes, the block sends later writes to one of three places: the input mask, a one-cycle end-of-interrupt/priority command strobe, or the read-select, special-mask and poll controls. The outputs are the captured configuration fields and the command strobes. These are used by the priority resolver and the bus read logic, which are separate blocks.

Top module: `irqc_cfg_decoder`

## Requirements
- R1: After reset, `init_done`, `irq_mask`, every configuration field, `spec_mask`, `eoi_stb` and `poll_stb` are 0, and `read_irr` is 1 (request register selected).
- R2: A write with `wr_addr`=0 and `wr_data[4]`=1 is a start word in any state. It restarts the sequence and drops `init_done`. It captures bit 3 as `level_mode`, bit 2 as `vec_4byte`, bit 1 as `single_mode` and bit 0 as "mode word follows". It clears `irq_mask`, `casc_map`, the mode-word fields and `spec_mask`, and sets `read_irr` to 1.
- R3: The first `wr_addr`=1 write after a start word loads `vec_base` from `wr_data[7:3]`.
- R4: If `single_mode`=0, the next `wr_addr`=1 write loads `casc_map` from all 8 data bits. If `single_mode`=1, that step is skipped.
- R5: If the start word had bit 0 set, the next `wr_addr`=1 write is the mode word. It sets `cpu86_mode` from bit 0, `auto_eoi` from bit 1, `buf_mode` from bits 3:2 and `nested_special` from bit 4. Without bit 0 set, these fields stay 0.
- R6: `init_done` rises one clock after the last word the start word called for.
- R7: While `init_done`=0, `wr_addr`=1 writes never change `irq_mask`, and `wr_addr`=0 writes with bit 4 = 0 have no effect. Before any start word has been seen, `wr_addr`=1 writes are ignored as well.
- R8: With `init_done`=1, every `wr_addr`=1 write loads `irq_mask` with the full data byte (1 = input masked).
- R9: With `init_done`=1, a `wr_addr`=0 write with bits 4:3 = 00 pulses `eoi_stb`. It presents `eoi_code` = bits 7:5 and `eoi_level` = bits 2:0.
- R10: With `init_done`=1, a `wr_addr`=0 write with bits 4:3 = 01 sets `read_irr` to bit 0 only when bit 1 is 1. Otherwise `read_irr` is unchanged.
- R11: In that same command, bit 6 = 1 loads `spec_mask` from bit 5. With bit 6 = 0, `spec_mask` is unchanged.
- R12: In that same command, bit 2 = 1 pulses `poll_stb`.
- R13: All outputs change on the clock edge that takes the write. `eoi_stb` and `poll_stb` last exactly one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable, one cycle per write |
| wr_addr | input | 1 | Register address bit |
| wr_data | input | 8 | Write data |
| init_done | output | 1 | Start-up sequence complete |
| vec_base | output | 5 | Upper five bits of the interrupt vector |
| vec_4byte | output | 1 | 1 = 4-byte vector spacing, 0 = 8-byte |
| level_mode | output | 1 | 1 = level-sensitive inputs, 0 = edge |
| single_mode | output | 1 | 1 = single controller, 0 = cascaded |
| casc_map | output | 8 | Cascade word contents |
| cpu86_mode | output | 1 | Mode word bit 0 |
| auto_eoi | output | 1 | Automatic end of interrupt |
| buf_mode | output | 2 | Buffering mode field |
| nested_special | output | 1 | Special fully nested mode |
| irq_mask | output | 8 | Input mask register |
| read_irr | output | 1 | 1 = read request register, 0 = in-service |
| spec_mask | output | 1 | Special mask mode |
| eoi_stb | output | 1 | One-cycle EOI/priority command strobe |
| eoi_code | output | 3 | Command code from bits 7:5 |
| eoi_level | output | 3 | Level from bits 2:0 |
| poll_stb | output | 1 | One-cycle poll command strobe |

## Verification
Every result here comes from a single register stage. A write presented before a rising edge is therefore visible right after that edge, and the strobes fall after the edge that follows. The bench drives each write on a falling edge, drops the enable on the next falling edge and samples the outputs there. Each sample lands half a cycle after the capturing edge and before the next edge could clear a strobe. A separate idle-cycle sample confirms that each strobe goes low again.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W  = 8;
    localparam int VBASE_W = 5;
    localparam int LVL_W   = 3;
    localparam int CODE_W  = 3;
    localparam int BUF_W   = 2;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_WAIT_VEC,
        ST_WAIT_CASC,
        ST_WAIT_MODE,
        ST_READY
    } seq_st_e;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_START,
        WK_ODD,
        WK_CMD,
        WK_SEL
    } wr_kind_e;

    typedef struct packed {
        logic [VBASE_W-1:0] vec_base;
        logic               vec_4byte;
        logic               level_mode;
        logic               single_mode;
        logic               mode_needed;
        logic [DATA_W-1:0]  casc_map;
        logic               cpu86_mode;
        logic               auto_eoi;
        logic [BUF_W-1:0]   buf_mode;
        logic               nested_special;
    } init_cfg_t;

    function automatic wr_kind_e classify(input logic en, input logic a,
                                          input logic [DATA_W-1:0] d);
        if (!en)       return WK_NONE;
        else if (a)    return WK_ODD;
        else if (d[4]) return WK_START;
        else if (d[3]) return WK_SEL;
        else           return WK_CMD;
    endfunction

    function automatic seq_st_e after_vec(input init_cfg_t c);
        if (!c.single_mode)    return ST_WAIT_CASC;
        else if (c.mode_needed) return ST_WAIT_MODE;
        else                    return ST_READY;
    endfunction

    function automatic seq_st_e after_casc(input init_cfg_t c);
        return c.mode_needed ? ST_WAIT_MODE : ST_READY;
    endfunction

endpackage

// File: rtl/irqc_wr_classify.sv
module irqc_wr_classify
    import irqc_pkg::*;
(
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_kind_e          kind
);
    always_comb kind = classify(wr_en, wr_addr, wr_data);
endmodule

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_kind_e          kind,
    input  logic [DATA_W-1:0] wr_data,
    output init_cfg_t         cfg,
    output logic              ready
);
    seq_st_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_UNINIT;
            cfg  <= '0;
        end else if (kind == WK_START) begin
            cfg             <= '0;
            cfg.level_mode  <= wr_data[3];
            cfg.vec_4byte   <= wr_data[2];
            cfg.single_mode <= wr_data[1];
            cfg.mode_needed <= wr_data[0];
            st_q            <= ST_WAIT_VEC;
        end else if (kind == WK_ODD) begin
            case (st_q)
                ST_WAIT_VEC: begin
                    cfg.vec_base <= wr_data[DATA_W-1 -: VBASE_W];
                    st_q         <= after_vec(cfg);
                end
                ST_WAIT_CASC: begin
                    cfg.casc_map <= wr_data;
                    st_q         <= after_casc(cfg);
                end
                ST_WAIT_MODE: begin
                    cfg.cpu86_mode     <= wr_data[0];
                    cfg.auto_eoi       <= wr_data[1];
                    cfg.buf_mode       <= wr_data[3:2];
                    cfg.nested_special <= wr_data[4];
                    st_q               <= ST_READY;
                end
                default: st_q <= st_q;
            endcase
        end
    end

    assign ready = (st_q == ST_READY);
endmodule

// File: rtl/irqc_op_regs.sv
module irqc_op_regs
    import irqc_pkg::*;
#(
    parameter int MASK_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_kind_e          kind,
    input  logic              ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic [MASK_W-1:0] irq_mask,
    output logic              read_irr,
    output logic              spec_mask,
    output logic              eoi_stb,
    output logic [CODE_W-1:0] eoi_code,
    output logic [LVL_W-1:0]  eoi_level,
    output logic              poll_stb
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_mask  <= '0;
            read_irr  <= 1'b1;
            spec_mask <= 1'b0;
            eoi_stb   <= 1'b0;
            eoi_code  <= '0;
            eoi_level <= '0;
            poll_stb  <= 1'b0;
        end else begin
            eoi_stb  <= 1'b0;
            poll_stb <= 1'b0;
            if (kind == WK_START) begin
                irq_mask  <= '0;
                read_irr  <= 1'b1;
                spec_mask <= 1'b0;
            end else if (ready) begin
                case (kind)
                    WK_ODD: irq_mask <= wr_data[MASK_W-1:0];
                    WK_CMD: begin
                        eoi_stb   <= 1'b1;
                        eoi_code  <= wr_data[DATA_W-1 -: CODE_W];
                        eoi_level <= wr_data[LVL_W-1:0];
                    end
                    WK_SEL: begin
                        if (wr_data[1]) read_irr  <= wr_data[0];
                        if (wr_data[6]) spec_mask <= wr_data[5];
                        poll_stb <= wr_data[2];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/irqc_cfg_decoder.sv
module irqc_cfg_decoder
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               init_done,
    output logic [VBASE_W-1:0] vec_base,
    output logic               vec_4byte,
    output logic               level_mode,
    output logic               single_mode,
    output logic [DATA_W-1:0]  casc_map,
    output logic               cpu86_mode,
    output logic               auto_eoi,
    output logic [BUF_W-1:0]   buf_mode,
    output logic               nested_special,
    output logic [DATA_W-1:0]  irq_mask,
    output logic               read_irr,
    output logic               spec_mask,
    output logic               eoi_stb,
    output logic [CODE_W-1:0]  eoi_code,
    output logic [LVL_W-1:0]   eoi_level,
    output logic               poll_stb
);
    wr_kind_e  kind;
    init_cfg_t cfg;
    logic      ready;

    irqc_wr_classify u_cls (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .kind(kind)
    );

    irqc_init_seq u_seq (
        .clk(clk), .rst(rst), .kind(kind), .wr_data(wr_data),
        .cfg(cfg), .ready(ready)
    );

    irqc_op_regs #(.MASK_W(DATA_W)) u_ops (
        .clk(clk), .rst(rst), .kind(kind), .ready(ready), .wr_data(wr_data),
        .irq_mask(irq_mask), .read_irr(read_irr), .spec_mask(spec_mask),
        .eoi_stb(eoi_stb), .eoi_code(eoi_code), .eoi_level(eoi_level),
        .poll_stb(poll_stb)
    );

    assign init_done      = ready;
    assign vec_base       = cfg.vec_base;
    assign vec_4byte      = cfg.vec_4byte;
    assign level_mode     = cfg.level_mode;
    assign single_mode    = cfg.single_mode;
    assign casc_map       = cfg.casc_map;
    assign cpu86_mode     = cfg.cpu86_mode;
    assign auto_eoi       = cfg.auto_eoi;
    assign buf_mode       = cfg.buf_mode;
    assign nested_special = cfg.nested_special;
endmodule

// File: rtl/irqc_cfg_decoder_chk.sv
module irqc_cfg_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_addr,
    input logic [7:0] wr_data,
    input logic       init_done,
    input logic [7:0] irq_mask,
    input logic       read_irr,
    input logic       spec_mask,
    input logic       eoi_stb,
    input logic [2:0] eoi_code,
    input logic [2:0] eoi_level,
    input logic       poll_stb
);
    // R2
    start_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr && wr_data[4]) |=> (!init_done && irq_mask == 8'h00 && read_irr && !spec_mask));

    // R7
    mask_hold_before_init_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_done && wr_en && wr_addr) |=> (irq_mask == $past(irq_mask)));

    // R7
    no_cmd_before_init_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_done) |=> (!eoi_stb && !poll_stb));

    // R8
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        (init_done && wr_en && wr_addr) |=> (irq_mask == $past(wr_data)));

    // R9
    eoi_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (init_done && wr_en && !wr_addr && wr_data[4:3] == 2'b00)
        |=> (eoi_stb && eoi_code == $past(wr_data[7:5]) && eoi_level == $past(wr_data[2:0])));

    // R11
    smask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (init_done && wr_en && !wr_addr && wr_data[4:3] == 2'b01 && !wr_data[6])
        |=> $stable(spec_mask));

    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eoi_stb, poll_stb}));

    // R13
    eoi_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_stb && !wr_en) |=> !eoi_stb);
endmodule

bind irqc_cfg_decoder irqc_cfg_decoder_chk chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .init_done(init_done), .irq_mask(irq_mask), .read_irr(read_irr),
    .spec_mask(spec_mask), .eoi_stb(eoi_stb), .eoi_code(eoi_code),
    .eoi_level(eoi_level), .poll_stb(poll_stb)
);

// File: tb/irqc_cfg_decoder_tb_top.sv
module irqc_cfg_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic init_done, vec_4byte, level_mode, single_mode, cpu86_mode, auto_eoi;
    logic nested_special, read_irr, spec_mask, eoi_stb, poll_stb;
    logic [4:0] vec_base;
    logic [7:0] casc_map, irq_mask;
    logic [1:0] buf_mode;
    logic [2:0] eoi_code, eoi_level;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_cfg_decoder dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .init_done(init_done), .vec_base(vec_base), .vec_4byte(vec_4byte),
        .level_mode(level_mode), .single_mode(single_mode), .casc_map(casc_map),
        .cpu86_mode(cpu86_mode), .auto_eoi(auto_eoi), .buf_mode(buf_mode),
        .nested_special(nested_special), .irq_mask(irq_mask), .read_irr(read_irr),
        .spec_mask(spec_mask), .eoi_stb(eoi_stb), .eoi_code(eoi_code),
        .eoi_level(eoi_level), .poll_stb(poll_stb)
    );

    // {addr, data, exp_init, exp_mask, exp_read_irr, exp_spec_mask, exp_eoi, exp_poll, req}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b0, 8'h11, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 start, cascade, mode word
        {1'b1, 8'h55, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 vector word, mask untouched
        {1'b1, 8'h04, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 cascade word
        {1'b0, 8'h20, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 command during start-up
        {1'b1, 8'h1F, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 mode word completes
        {1'b1, 8'hA5, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 mask load
        {1'b0, 8'h63, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 EOI command
        {1'b0, 8'h0A, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 select in-service
        {1'b0, 8'h09, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 no enable, hold
        {1'b0, 8'h68, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 4'd11}, // R11 set special mask
        {1'b0, 8'h28, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 4'd11}, // R11 no enable, hold
        {1'b0, 8'h0C, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b1, 4'd12}, // R12 poll
        {1'b0, 8'h48, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 clear special mask
        {1'b0, 8'h13, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 restart, single
        {1'b1, 8'hF8, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 cascade word skipped
        {1'b1, 8'h02, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 mode word
        {1'b1, 8'h3C, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8}   // R8 mask load
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 init_done", init_done, 0);
        check("R1 mask", irq_mask, 0);
        check("R1 read_irr", read_irr, 1);
        check("R1 config", {vec_base, vec_4byte, level_mode, single_mode, casc_map,
                            cpu86_mode, auto_eoi, buf_mode, nested_special}, 0);
        check("R1 strobes", {spec_mask, eoi_stb, poll_stb}, 0);

        // R7 writes before any start word
        wr(1'b1, 8'hFF);
        check("R7 uninit odd mask", irq_mask, 0);
        check("R7 uninit odd init", init_done, 0);
        wr(1'b0, 8'h20);
        check("R7 uninit cmd", eoi_stb, 0);
        wr(1'b0, 8'h0A);
        check("R7 uninit select", read_irr, 1);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [25:0] v;
            logic [3:0] rq;
            v = VEC[i];
            rq = v[3:0];
            wr(v[25], v[24:17]);
            check($sformatf("R%0d vec%0d init", rq, i), init_done, v[16]);
            check($sformatf("R%0d vec%0d mask", rq, i), irq_mask, v[15:8]);
            check($sformatf("R%0d vec%0d read_irr", rq, i), read_irr, v[7]);
            check($sformatf("R%0d vec%0d spec_mask", rq, i), spec_mask, v[6]);
            check($sformatf("R%0d vec%0d eoi_stb", rq, i), eoi_stb, v[5]);
            check($sformatf("R%0d vec%0d poll", rq, i), poll_stb, v[4]);
            if (v[5]) begin
                check($sformatf("R9 vec%0d code", i), eoi_code, v[24:22]);
                check($sformatf("R9 vec%0d level", i), eoi_level, v[19:17]);
                idle();
                check("R13 eoi one cycle", eoi_stb, 0);
            end
            if (v[4]) begin
                idle();
                check("R13 poll one cycle", poll_stb, 0);
            end
        end
        // R3 R4 R5 final config from single + mode word 02
        check("R3 vec_base", vec_base, 5'h1F);
        check("R4 single casc", {single_mode, casc_map}, {1'b1, 8'h00});
        check("R5 mode fields", {cpu86_mode, auto_eoi, buf_mode, nested_special}, 5'b01000);

        // R3 R4 R5 cascaded start-up with all mode bits
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h1F);
        check("R3 vec_base casc", vec_base, 5'h0A);
        check("R4 casc_map", casc_map, 8'h04);
        check("R5 mode fields full", {cpu86_mode, auto_eoi, buf_mode, nested_special}, 5'b11111);
        check("R2 level/vec4/single", {level_mode, vec_4byte, single_mode}, 3'b000);

        // R2 restart mid-sequence; R6 no mode word, single
        wr(1'b0, 8'h11);
        wr(1'b0, 8'h1A);
        check("R2 restart init low", init_done, 0);
        wr(1'b1, 8'h20);
        check("R6 done after vector", init_done, 1);
        check("R2 level/vec4/single", {level_mode, vec_4byte, single_mode}, 3'b101);
        check("R5 no mode word", {cpu86_mode, auto_eoi, buf_mode, nested_special}, 5'b00000);
        check("R3 vec_base short", vec_base, 5'h04);
        wr(1'b1, 8'h81);
        check("R8 mask after short", irq_mask, 8'h81);

        // R1 reset from operating state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset again", {init_done, irq_mask, read_irr}, {1'b0, 8'h00, 1'b1});

        finished = 1;
        summary();
    end
endmodule